// File: doc/BRIEF.md
# Extended Interrupt Router with CPU-Number Routing

This block collects a bank of level-sensitive interrupt vectors and steers each one to the interrupt request line of one or more processors. Software programs the block through a simple 32-bit register bus. The bus carries a byte address, a write enable, four byte strobes, write data and registered read data. Each vector has an enable bit, a status bit that shows its sampled input level, and an 8-bit route byte.

The meaning of the route byte is chosen at run time by a configuration register. That register can only switch on what a read-only capability register advertises. In the grouped encoding, the upper nibble of the route byte names a group of four processors and the lower nibble is a bitmap of processors inside that group. In the direct encoding, the whole byte is a processor number. Each processor output is the registered OR of every vector that is pending, enabled and routed to it. The block-wide enable bit gates all of these outputs.

To move a vector to another processor, software masks that vector, rewrites its route byte and then unmasks it. The byte strobes let one route byte change without touching the three other route bytes that share its word.

Top module: `ext_irq_router`

## Requirements
- R1: After a synchronous reset, all enable bits, route bytes, status bits, the configuration register, every `irq_out` bit and `bus_rdata` are zero.
- R2: The capability register at address 0x40000000 reads back the `FEATURES` parameter and ignores writes. Its bits mean: bit 3 direct processor numbering, bit 2 interrupt encoding, bit 1 global enable option, bit 0 extension present.
- R3: The configuration register at 0x40000004 holds bit 1 (global enable), bit 2 (interrupt encoding) and bit 3 (direct numbering). It is written through strobe 0. A bit is stored only when the matching capability bit is 1. All other bits read as 0.
- R4: The enable bit of vector v is read/write at address 0x1600 + (v>>5)*4, bit v&31. A disabled vector never drives any output.
- R5: The status bit of vector v is read-only at address 0x1800 + (v>>5)*4, bit v&31. It shows the level of `irq_in[v]` as it was at the previous clock edge.
- R6: The route byte of vector v sits at address 0x1C00 + (v & ~3), bits (v&3)*8 upward. A write changes only the byte lanes whose `bus_wstrb` bit is 1.
- R7: When configuration bit 3 is 0, route byte {g[3:0], m[3:0]} targets processor g*4+i for each set bit i of m. Targets at or above `NUM_CPU` are dropped.
- R8: When configuration bit 3 is 1, the route byte is a processor number. The vector reaches only that processor, or no processor if the number is `NUM_CPU` or more.
- R9: `irq_out[c]` is the OR of all vectors that are pending, enabled and routed to c. It is forced to 0 when the global enable is off. The global enable is on when configuration bit 1 is 1, or always when capability bit 1 is 0. The output is registered: it follows a register write one cycle later and an input change two cycles later.
- R10: Requests follow the input level, and a request drops when its input drops. While a vector is masked during a reroute, it raises no request on any processor.
- R11: `bus_rdata` returns, one cycle later, the register at the address presented. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_VEC | Level-sensitive interrupt inputs |
| irq_out | output | NUM_CPU | Registered request line per processor |

## Verification
The bench goes after the route decode in both encodings. A decoder that mixed up group and bitmap, or did not drop out-of-range processor numbers, would light the wrong output bits. A partial-strobe write is read back: a design that ignored strobes would overwrite the neighbouring route byte of the same word. The reroute sequence is stepped through with the output checked at each step, so a design that let a masked vector through, or that took the enable from the wrong bit, would raise a request in the middle of it. Configuration bits without capability backing, and writes to the capability register, are read back to catch a register that stores what it should refuse.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam logic [31:0] EN_BASE   = 32'h0000_1600;
  localparam logic [31:0] ST_BASE   = 32'h0000_1800;
  localparam logic [31:0] RT_BASE   = 32'h0000_1C00;
  localparam logic [31:0] FEAT_ADDR = 32'h4000_0000;
  localparam logic [31:0] CFG_ADDR  = 32'h4000_0004;

  localparam int CFG_GLB_EN  = 1;
  localparam int CFG_INT_ENC = 2;
  localparam int CFG_CPU_ENC = 3;

  localparam logic [3:0] CFG_IMPL = 4'b1110;

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  strb);
    logic [31:0] res;
    res = old_w;
    for (int l = 0; l < 4; l++) begin
      if (strb[l]) res[l*8 +: 8] = new_w[l*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int          NUM_VEC  = 256,
  parameter logic [31:0] FEATURES = 32'h0000_000B
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          bus_addr,
  input  logic                 bus_we,
  input  logic [3:0]           bus_wstrb,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_VEC-1:0]   irq_in,
  output logic [NUM_VEC-1:0]   en_vec,
  output logic [NUM_VEC-1:0]   st_vec,
  output logic [NUM_VEC*8-1:0] route_flat,
  output logic                 glb_en,
  output logic                 cpu_enc
);

  localparam int EN_WORDS = NUM_VEC / 32;
  localparam int RT_WORDS = NUM_VEC / 4;
  localparam int EN_IW    = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int RT_IW    = (RT_WORDS > 1) ? $clog2(RT_WORDS) : 1;
  localparam logic [3:0] CFG_MASK = CFG_IMPL & FEATURES[3:0];

  logic [31:0]        en_q [EN_WORDS];
  logic [31:0]        rt_q [RT_WORDS];
  logic [3:0]         cfg_q;
  logic [NUM_VEC-1:0] st_q;
  logic [31:0]        rd_q, rd_nxt;

  logic [31:0]      en_off, st_off, rt_off;
  logic             en_hit, st_hit, rt_hit;
  logic [EN_IW-1:0] en_idx, st_idx;
  logic [RT_IW-1:0] rt_idx;

  assign en_off = bus_addr - EN_BASE;
  assign st_off = bus_addr - ST_BASE;
  assign rt_off = bus_addr - RT_BASE;
  assign en_hit = (en_off < 32'(EN_WORDS * 4)) && (en_off[1:0] == 2'b00);
  assign st_hit = (st_off < 32'(EN_WORDS * 4)) && (st_off[1:0] == 2'b00);
  assign rt_hit = (rt_off < 32'(RT_WORDS * 4)) && (rt_off[1:0] == 2'b00);
  assign en_idx = en_off[EN_IW+1:2];
  assign st_idx = st_off[EN_IW+1:2];
  assign rt_idx = rt_off[RT_IW+1:2];

  // enable words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < EN_WORDS; w++) en_q[w] <= '0;
    end else if (bus_we && en_hit) begin
      en_q[en_idx] <= merge_lanes(en_q[en_idx], bus_wdata, bus_wstrb);
    end
  end

  // route words, byte-lane writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < RT_WORDS; w++) rt_q[w] <= '0;
    end else if (bus_we && rt_hit) begin
      rt_q[rt_idx] <= merge_lanes(rt_q[rt_idx], bus_wdata, bus_wstrb);
    end
  end

  // configuration, gated by capabilities
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (bus_we && bus_wstrb[0] && (bus_addr == CFG_ADDR)) begin
      cfg_q <= bus_wdata[3:0] & CFG_MASK;
    end
  end

  // sampled input levels
  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= irq_in;
  end

  always_comb begin
    rd_nxt = '0;
    if (en_hit)                      rd_nxt = en_q[en_idx];
    else if (st_hit)                 rd_nxt = st_q[32*int'(st_idx) +: 32];
    else if (rt_hit)                 rd_nxt = rt_q[rt_idx];
    else if (bus_addr == FEAT_ADDR)  rd_nxt = FEATURES;
    else if (bus_addr == CFG_ADDR)   rd_nxt = {28'b0, cfg_q};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign bus_rdata = rd_q;
  assign st_vec    = st_q;
  assign glb_en    = cfg_q[CFG_GLB_EN] | ~FEATURES[CFG_GLB_EN];
  assign cpu_enc   = cfg_q[CFG_CPU_ENC];

  for (genvar w = 0; w < EN_WORDS; w++) begin : g_en
    assign en_vec[w*32 +: 32] = en_q[w];
  end
  for (genvar w = 0; w < RT_WORDS; w++) begin : g_rt
    assign route_flat[w*32 +: 32] = rt_q[w];
  end

  // R3: no configuration bit survives without capability backing
  p_cfg_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == CFG_ADDR)) |=> ((cfg_q & ~FEATURES[3:0]) == 4'b0));

  // R6: an unstrobed lane of a route word keeps its byte
  p_route_lane_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == RT_BASE) && !bus_wstrb[1]) |=> $stable(rt_q[0][15:8]));

  // R2: capability register reads are never altered by a write
  p_feat_ro_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == FEAT_ADDR) |=> (bus_rdata == FEATURES));

endmodule

// File: rtl/ext_irq_decode.sv
module ext_irq_decode #(
  parameter int NUM_VEC = 256,
  parameter int NUM_CPU = 8
) (
  input  logic [NUM_VEC*8-1:0]       route_flat,
  input  logic                       cpu_enc,
  output logic [NUM_VEC*NUM_CPU-1:0] hit
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [7:0] rb;
    assign rb = route_flat[v*8 +: 8];
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      localparam int GRP  = c / 4;
      localparam int SLOT = c % 4;
      logic direct_hit, group_hit;
      assign direct_hit = (rb == 8'(c));
      if (GRP < 16) begin : g_reach
        assign group_hit = (rb[7:4] == 4'(GRP)) && rb[SLOT];
      end else begin : g_far
        assign group_hit = 1'b0;
      end
      assign hit[v*NUM_CPU + c] = cpu_enc ? direct_hit : group_hit;
    end
  end

endmodule

// File: rtl/ext_irq_collect.sv
module ext_irq_collect #(
  parameter int NUM_VEC = 256,
  parameter int NUM_CPU = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_VEC-1:0]         active,
  input  logic [NUM_VEC*NUM_CPU-1:0] hit,
  input  logic                       glb_en,
  output logic [NUM_CPU-1:0]         irq_out
);

  logic [NUM_CPU-1:0] any_nxt, out_q;

  always_comb begin
    any_nxt = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (active[v] && hit[v*NUM_CPU + c]) any_nxt[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (glb_en) out_q <= any_nxt;
    else             out_q <= '0;
  end

  assign irq_out = out_q;

  // R9: global enable off silences every processor line
  p_glb_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> (irq_out == '0));

  // R10: with nothing pending and enabled, no request follows
  p_no_source_r10: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |=> (irq_out == '0));

endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router #(
  parameter int          NUM_VEC  = 256,
  parameter int          NUM_CPU  = 8,
  parameter logic [31:0] FEATURES = 32'h0000_000B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        bus_addr,
  input  logic               bus_we,
  input  logic [3:0]         bus_wstrb,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_VEC-1:0] irq_in,
  output logic [NUM_CPU-1:0] irq_out
);

  logic [NUM_VEC-1:0]         en_vec, st_vec, active;
  logic [NUM_VEC*8-1:0]       route_flat;
  logic [NUM_VEC*NUM_CPU-1:0] hit;
  logic                       glb_en, cpu_enc;

  ext_irq_regs #(.NUM_VEC(NUM_VEC), .FEATURES(FEATURES)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wstrb(bus_wstrb),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .en_vec(en_vec), .st_vec(st_vec),
    .route_flat(route_flat), .glb_en(glb_en), .cpu_enc(cpu_enc)
  );

  ext_irq_decode #(.NUM_VEC(NUM_VEC), .NUM_CPU(NUM_CPU)) u_dec (
    .route_flat(route_flat), .cpu_enc(cpu_enc), .hit(hit)
  );

  assign active = en_vec & st_vec;

  ext_irq_collect #(.NUM_VEC(NUM_VEC), .NUM_CPU(NUM_CPU)) u_col (
    .clk(clk), .rst(rst), .active(active), .hit(hit),
    .glb_en(glb_en), .irq_out(irq_out)
  );

  // R4: a masked vector alone cannot light any line
  p_masked_r4: assert property (@(posedge clk) disable iff (rst)
    ((st_vec & en_vec) == '0) |=> (irq_out == '0));

endmodule

// File: tb/ext_irq_router_test.sv
module ext_irq_router_test;

  localparam int NV = 256;
  localparam int NC = 8;
  localparam logic [31:0] FEAT = 32'h0000_000B;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [3:0]    bus_wstrb = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NV-1:0] irq_in = '0;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_router #(.NUM_VEC(NV), .NUM_CPU(NC), .FEATURES(FEAT)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]    m_route [NV];
  bit            m_en    [NV];
  bit            m_st    [NV];
  logic [3:0]    m_cfg;
  logic [NC-1:0] m_out;
  logic [31:0]   m_rd;

  function automatic bit m_targets(input logic [7:0] rb, input int c);
    if (m_cfg[3]) return (int'(rb) == c);
    return (int'(rb[7:4]) == c / 4) && rb[c % 4];
  endfunction

  function automatic logic [NC-1:0] m_calc();
    logic [NC-1:0] o = '0;
    bit ge = m_cfg[1] || !FEAT[1];
    for (int c = 0; c < NC; c++)
      for (int v = 0; v < NV; v++)
        if (ge && m_en[v] && m_st[v] && m_targets(m_route[v], c)) o[c] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] m_read(input logic [31:0] a);
    logic [31:0] r = '0;
    if (a >= 32'h1600 && a < 32'h1620 && a[1:0] == 0) begin
      for (int b = 0; b < 32; b++) r[b] = m_en[(a - 32'h1600) / 4 * 32 + b];
    end else if (a >= 32'h1800 && a < 32'h1820 && a[1:0] == 0) begin
      for (int b = 0; b < 32; b++) r[b] = m_st[(a - 32'h1800) / 4 * 32 + b];
    end else if (a >= 32'h1C00 && a < 32'h1D00 && a[1:0] == 0) begin
      for (int l = 0; l < 4; l++) r[l*8 +: 8] = m_route[a - 32'h1C00 + l];
    end else if (a == 32'h4000_0000) r = FEAT;
    else if (a == 32'h4000_0004) r = {28'b0, m_cfg};
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NV; v++) begin
        m_route[v] <= '0; m_en[v] <= 0; m_st[v] <= 0;
      end
      m_cfg <= '0; m_out <= '0; m_rd <= '0;
    end else begin
      m_out <= m_calc();
      m_rd  <= m_read(bus_addr);
      for (int v = 0; v < NV; v++) m_st[v] <= irq_in[v];
      if (bus_we) begin
        if (bus_addr >= 32'h1600 && bus_addr < 32'h1620 && bus_addr[1:0] == 0)
          for (int b = 0; b < 32; b++)
            if (bus_wstrb[b/8]) m_en[(bus_addr - 32'h1600) / 4 * 32 + b] <= bus_wdata[b];
        if (bus_addr >= 32'h1C00 && bus_addr < 32'h1D00 && bus_addr[1:0] == 0)
          for (int l = 0; l < 4; l++)
            if (bus_wstrb[l]) m_route[bus_addr - 32'h1C00 + l] <= bus_wdata[l*8 +: 8];
        if (bus_addr == 32'h4000_0004 && bus_wstrb[0])
          m_cfg <= bus_wdata[3:0] & FEAT[3:0] & 4'b1110;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (!done) begin
      checks++;
      if (irq_out !== m_out) begin
        errors++;
        $display("FAIL R9 model irq_out actual %h expected %h at %0t", irq_out, m_out, $time);
      end
      checks++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R11 model rdata actual %h expected %h at %0t", bus_rdata, m_rd, $time);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #2 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 0);
    rd(32'h4000_0004, r); chk("R1 config", r, 0);
    rd(32'h1C04, r);      chk("R1 route word", r, 0);
    rd(32'h1600, r);      chk("R1 enable word", r, 0);

    // R2 capability register, read-only
    rd(32'h4000_0000, r); chk("R2 features", r, FEAT);
    wr(32'h4000_0000, 32'hFFFF_FFFF, 4'hF);
    rd(32'h4000_0000, r); chk("R2 features after write", r, FEAT);

    // R3 unsupported and reserved config bits are dropped
    wr(32'h4000_0004, 32'hF, 4'hF);
    rd(32'h4000_0004, r); chk("R3 config gated", r, 32'hA);

    // R7 grouped routing: group 1, slots 0 and 1 -> processors 4 and 5
    wr(32'h4000_0004, 32'h2, 4'h1);
    wr(32'h1600, 32'h20, 4'hF);
    rd(32'h1600, r); chk("R4 enable readback", r, 32'h20);
    irq_in[5] = 1'b1;
    wr(32'h1C04, 32'h0000_1300, 4'hF);
    settle();
    rd(32'h1800, r); chk("R5 status word", r, 32'h20);
    chk("R7 group 1 slots 0,1", 32'(irq_out), 32'h30);

    // R7 group beyond processor count
    wr(32'h1C04, 32'h0000_2100, 4'h2);
    settle();
    chk("R7 group out of range", 32'(irq_out), 0);

    // R8 direct numbering
    wr(32'h4000_0004, 32'hA, 4'h1);
    wr(32'h1C04, 32'h0000_0600, 4'h2);
    settle();
    chk("R8 direct cpu 6", 32'(irq_out), 32'h40);
    wr(32'h1C04, 32'h0000_1300, 4'h2);
    settle();
    chk("R8 direct out of range", 32'(irq_out), 0);
    wr(32'h1C04, 32'h0000_0600, 4'h2);

    // R9 global enable gating
    wr(32'h4000_0004, 32'h8, 4'h1);
    settle();
    chk("R9 global off", 32'(irq_out), 0);
    wr(32'h4000_0004, 32'hA, 4'h1);
    settle();
    chk("R9 global on", 32'(irq_out), 32'h40);

    // R6 partial strobe keeps lane 1
    wr(32'h1C04, 32'h4433_2211, 4'b1101);
    rd(32'h1C04, r); chk("R6 lane merge", r, 32'h4433_0611);
    chk("R6 route kept", 32'(irq_out), 32'h40);

    // R10 reroute sequence: mask, move, unmask
    wr(32'h1600, 32'hFFFF_FFDF, 4'hF);
    settle();
    chk("R10 masked", 32'(irq_out), 0);
    wr(32'h1C04, 32'h0000_0200, 4'h2);
    settle();
    chk("R10 masked after move", 32'(irq_out), 0);
    wr(32'h1600, 32'hFFFF_FFFF, 4'hF);
    settle();
    chk("R10 unmasked to cpu 2", 32'(irq_out), 32'h04);

    // R10 level follows input
    irq_in[5] = 1'b0;
    settle();
    chk("R10 level drop", 32'(irq_out), 0);
    rd(32'h1800, r); chk("R5 status cleared", r, 0);

    // R9 OR over several vectors
    wr(32'h1C64, 32'h07, 4'h1);
    wr(32'h1CC8, 32'h02, 4'h1);
    wr(32'h160C, 32'h10, 4'hF);
    wr(32'h1618, 32'h100, 4'hF);
    irq_in[100] = 1'b1; irq_in[200] = 1'b1; irq_in[5] = 1'b1;
    settle();
    chk("R9 or of vectors", 32'(irq_out), 32'h84);
    wr(32'h1618, 32'h0, 4'hF);
    settle();
    chk("R4 vec 200 off, vec 5 holds", 32'(irq_out), 32'h84);
    wr(32'h1600, 32'h0, 4'hF);
    settle();
    chk("R4 vec 5 off", 32'(irq_out), 32'h80);

    // R9 two-cycle input latency
    @(negedge clk);
    irq_in[100] = 1'b0;
    @(posedge clk); #2;
    chk("R9 latency first edge", 32'(irq_out), 32'h80);
    @(posedge clk); #2;
    chk("R9 latency second edge", 32'(irq_out), 0);

    // R11 unmapped read
    rd(32'h1500, r); chk("R11 unmapped", r, 0);

    settle();
    finish_run();
  end

endmodule